// File: doc/BRIEF.md
# Eight-Port Omega Interconnect

This block is a one-way multistage network that joins eight sources to eight sinks. Each source offers a valid flag, a destination index and a data payload. Each packet passes through a chain of 2x2 exchange boxes. A perfect shuffle (the link index rotated left by one bit) comes before every rank of boxes. Each rank reads one destination bit, starting from the most significant, to set the box to pass straight or to cross. After the last rank, a packet sits on the sink whose index equals its destination.

The network is not a crossbar. Some sets of simultaneous packets need the same box output. In that case the box passes the packet from its lower-numbered input and drops the other one. The dropped packet's source is reported on a per-source blocked flag, and the packet appears at no sink. The routing path is purely combinational. A parameter adds one register rank on the sink side, and that rank also times the blocked flags. The block does not buffer, retry or apply back-pressure.

Top module: `omega_net`

## Requirements
- R1: With the output register enabled, every sink valid flag and every blocked flag reads 0 while reset is held, whatever the inputs are.
- R2: A packet that is not blocked appears on the sink whose index equals its 3-bit destination. It carries its own data and its source index on that sink's source field.
- R3: When two valid packets need the same output of one box, the packet on the box's lower-numbered input passes. The other packet's source gets its blocked flag set and reaches no sink. Example: source 0 to sink 3 and source 4 to sink 2 share the first-rank box 0, and source 4 is blocked.
- R4: An input with its valid flag at 0 never raises a blocked flag, never appears at a sink, and never stops another packet, whatever its destination field holds.
- R5: Every valid input is either delivered to exactly one sink or flagged blocked, never both. Each sink carries at most one packet.
- R6: With the output register enabled, sink and blocked values change at the first rising clock edge after the inputs change, and not before.
- R7: Every cyclic shift (destination = source + c modulo 8, for any c) with all inputs valid is delivered in full, with no blocked flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 8 | Per-source packet present flag |
| in_dst | input | 24 | Per-source destination index, 3 bits per source, source 0 in the low bits |
| in_data | input | 64 | Per-source payload, 8 bits per source |
| out_valid | output | 8 | Per-sink packet present flag |
| out_data | output | 64 | Per-sink payload, 8 bits per sink |
| out_src | output | 24 | Per-sink index of the source that delivered, 3 bits per sink |
| blocked | output | 8 | Per-source flag: packet dropped by a box conflict |

## Verification
Delivery and conflict resolution happen in the same cycle. One packet is routed to its sink while a box elsewhere in the network, or the same box, drops its rival. The bench provokes this with a directed pair that collides in the first rank next to packets that pass freely. It also uses many random destination sets in which several packets contend for one sink or one inner link. Each result is judged against a path model in the bench. The model places a packet after rank k at the index formed by a sliding three-bit window over the source bits followed by the destination bits, and it settles each collision in favour of the smaller box input index.

// File: rtl/omega_pkg.sv
package omega_pkg;

   // Perfect shuffle: rotate a link index of lg bits left by one position.
   function automatic int rotl_idx(input int idx, input int lg);
      int mask;
      mask = (1 << lg) - 1;
      return ((idx << 1) | (idx >> (lg - 1))) & mask;
   endfunction

endpackage

// File: rtl/omega_box.sv
// 2x2 exchange box. Input a is the lower-numbered input and wins ties.
module omega_box #(
   parameter int IDX_W   = 3,
   parameter int DATA_W  = 8,
   parameter int SEL_BIT = 2
) (
   input  logic              a_v,
   input  logic [IDX_W-1:0]  a_dst,
   input  logic [IDX_W-1:0]  a_src,
   input  logic [DATA_W-1:0] a_dat,
   input  logic              b_v,
   input  logic [IDX_W-1:0]  b_dst,
   input  logic [IDX_W-1:0]  b_src,
   input  logic [DATA_W-1:0] b_dat,
   output logic              u_v,
   output logic [IDX_W-1:0]  u_dst,
   output logic [IDX_W-1:0]  u_src,
   output logic [DATA_W-1:0] u_dat,
   output logic              l_v,
   output logic [IDX_W-1:0]  l_dst,
   output logic [IDX_W-1:0]  l_src,
   output logic [DATA_W-1:0] l_dat,
   output logic              lose_v,
   output logic [IDX_W-1:0]  lose_src
);

   logic a_up, a_dn, b_up, b_dn;

   always_comb begin
      a_up = a_v & ~a_dst[SEL_BIT];
      a_dn = a_v &  a_dst[SEL_BIT];
      b_up = b_v & ~b_dst[SEL_BIT];
      b_dn = b_v &  b_dst[SEL_BIT];

      u_v   = a_up | b_up;
      u_dst = a_up ? a_dst : b_dst;
      u_src = a_up ? a_src : b_src;
      u_dat = a_up ? a_dat : b_dat;

      l_v   = a_dn | b_dn;
      l_dst = a_dn ? a_dst : b_dst;
      l_src = a_dn ? a_src : b_src;
      l_dat = a_dn ? a_dat : b_dat;

      lose_v   = (a_up & b_up) | (a_dn & b_dn);
      lose_src = b_src;
   end

endmodule

// File: rtl/omega_stage.sv
// One rank: perfect-shuffle wiring followed by NPORT/2 exchange boxes.
module omega_stage #(
   parameter int NPORT   = 8,
   parameter int IDX_W   = 3,
   parameter int DATA_W  = 8,
   parameter int SEL_BIT = 2
) (
   input  logic [NPORT-1:0]        in_v,
   input  logic [NPORT*IDX_W-1:0]  in_dst,
   input  logic [NPORT*IDX_W-1:0]  in_src,
   input  logic [NPORT*DATA_W-1:0] in_dat,
   output logic [NPORT-1:0]        out_v,
   output logic [NPORT*IDX_W-1:0]  out_dst,
   output logic [NPORT*IDX_W-1:0]  out_src,
   output logic [NPORT*DATA_W-1:0] out_dat,
   output logic [NPORT-1:0]        lost
);

   localparam int NBOX = NPORT / 2;

   logic              sh_v   [NPORT];
   logic [IDX_W-1:0]  sh_dst [NPORT];
   logic [IDX_W-1:0]  sh_src [NPORT];
   logic [DATA_W-1:0] sh_dat [NPORT];

   logic              bx_lv  [NBOX];
   logic [IDX_W-1:0]  bx_ls  [NBOX];

   genvar p, j;
   generate
      for (p = 0; p < NPORT; p++) begin : g_shuffle
         localparam int Q = omega_pkg::rotl_idx(p, IDX_W);
         assign sh_v[Q]   = in_v[p];
         assign sh_dst[Q] = in_dst[p*IDX_W +: IDX_W];
         assign sh_src[Q] = in_src[p*IDX_W +: IDX_W];
         assign sh_dat[Q] = in_dat[p*DATA_W +: DATA_W];
      end

      for (j = 0; j < NBOX; j++) begin : g_box
         omega_box #(
            .IDX_W  (IDX_W),
            .DATA_W (DATA_W),
            .SEL_BIT(SEL_BIT)
         ) u_box (
            .a_v     (sh_v[2*j]),
            .a_dst   (sh_dst[2*j]),
            .a_src   (sh_src[2*j]),
            .a_dat   (sh_dat[2*j]),
            .b_v     (sh_v[2*j+1]),
            .b_dst   (sh_dst[2*j+1]),
            .b_src   (sh_src[2*j+1]),
            .b_dat   (sh_dat[2*j+1]),
            .u_v     (out_v[2*j]),
            .u_dst   (out_dst[(2*j)*IDX_W +: IDX_W]),
            .u_src   (out_src[(2*j)*IDX_W +: IDX_W]),
            .u_dat   (out_dat[(2*j)*DATA_W +: DATA_W]),
            .l_v     (out_v[2*j+1]),
            .l_dst   (out_dst[(2*j+1)*IDX_W +: IDX_W]),
            .l_src   (out_src[(2*j+1)*IDX_W +: IDX_W]),
            .l_dat   (out_dat[(2*j+1)*DATA_W +: DATA_W]),
            .lose_v  (bx_lv[j]),
            .lose_src(bx_ls[j])
         );
      end
   endgenerate

   // Map each box's dropped packet back onto its source index.
   always_comb begin
      lost = '0;
      for (int b = 0; b < NBOX; b++) begin
         if (bx_lv[b]) lost[bx_ls[b]] = 1'b1;
      end
   end

endmodule

// File: rtl/omega_net.sv
module omega_net #(
   parameter int NPORT   = 8,
   parameter int DATA_W  = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic [NPORT-1:0]                     in_valid,
   input  logic [NPORT*$clog2(NPORT)-1:0]       in_dst,
   input  logic [NPORT*DATA_W-1:0]              in_data,
   output logic [NPORT-1:0]                     out_valid,
   output logic [NPORT*DATA_W-1:0]              out_data,
   output logic [NPORT*$clog2(NPORT)-1:0]       out_src,
   output logic [NPORT-1:0]                     blocked
);

   localparam int IDX_W  = $clog2(NPORT);
   localparam int STAGES = IDX_W;

   generate
      if (NPORT < 2 || (NPORT & (NPORT - 1)) != 0) begin : g_bad_nport
         $error("omega_net: NPORT must be a power of two, at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("omega_net: DATA_W must be at least 1");
      end
   endgenerate

   logic [NPORT-1:0]        ch_v   [STAGES+1];
   logic [NPORT*IDX_W-1:0]  ch_dst [STAGES+1];
   logic [NPORT*IDX_W-1:0]  ch_src [STAGES+1];
   logic [NPORT*DATA_W-1:0] ch_dat [STAGES+1];
   logic [NPORT-1:0]        lost_m [STAGES];
   logic [NPORT-1:0]        blk_c;

   assign ch_v[0]   = in_valid;
   assign ch_dst[0] = in_dst;
   assign ch_dat[0] = in_data;

   genvar p, k;
   generate
      for (p = 0; p < NPORT; p++) begin : g_tag
         assign ch_src[0][p*IDX_W +: IDX_W] = IDX_W'(p);
      end

      for (k = 0; k < STAGES; k++) begin : g_rank
         omega_stage #(
            .NPORT  (NPORT),
            .IDX_W  (IDX_W),
            .DATA_W (DATA_W),
            .SEL_BIT(STAGES - 1 - k)
         ) u_stage (
            .in_v   (ch_v[k]),
            .in_dst (ch_dst[k]),
            .in_src (ch_src[k]),
            .in_dat (ch_dat[k]),
            .out_v  (ch_v[k+1]),
            .out_dst(ch_dst[k+1]),
            .out_src(ch_src[k+1]),
            .out_dat(ch_dat[k+1]),
            .lost   (lost_m[k])
         );
      end
   endgenerate

   always_comb begin
      blk_c = '0;
      for (int s = 0; s < STAGES; s++) blk_c = blk_c | lost_m[s];
   end

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               out_valid <= '0;
               out_data  <= '0;
               out_src   <= '0;
               blocked   <= '0;
            end else begin
               out_valid <= ch_v[STAGES];
               out_data  <= ch_dat[STAGES];
               out_src   <= ch_src[STAGES];
               blocked   <= blk_c;
            end
         end

         // R1: outputs cleared while reset is held
         a_r1_reset_clear: assert property (@(posedge clk)
            !rst_n |=> (out_valid == '0 && blocked == '0));

         // R6: registered outputs show the routing result of the previous edge
         a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> (out_valid == $past(ch_v[STAGES]) && blocked == $past(blk_c)));
      end else begin : g_comb
         assign out_valid = ch_v[STAGES];
         assign out_data  = ch_dat[STAGES];
         assign out_src   = ch_src[STAGES];
         assign blocked   = blk_c;
      end
   endgenerate

   // R5: each valid packet is either delivered or dropped
   a_r5_conserve: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(ch_v[STAGES]) + $countones(blk_c)) == $countones(in_valid));

   // R4: an idle input never reports a conflict
   a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_c & ~in_valid) == '0);

   generate
      for (p = 0; p < NPORT; p++) begin : g_chk
         // R2: a packet leaving the last rank sits on the sink named by its destination
         a_r2_lands_home: assert property (@(posedge clk) disable iff (!rst_n)
            ch_v[STAGES][p] |-> (ch_dst[STAGES][p*IDX_W +: IDX_W] == IDX_W'(p)));
      end
   endgenerate

endmodule

// File: tb/omega_net_test.sv
`timescale 1ns/1ps
module omega_net_test;

   localparam int N = 8;
   localparam int L = 3;
   localparam int W = 8;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [N-1:0]   in_valid = '0;
   logic [N*L-1:0] in_dst = '0;
   logic [N*W-1:0] in_data = '0;
   logic [N-1:0]   out_valid;
   logic [N*W-1:0] out_data;
   logic [N*L-1:0] out_src;
   logic [N-1:0]   blocked;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   int          mv [N];
   int          md [N];
   logic [W-1:0] mdat [N];
   int unsigned seed = 32'h1234_5678;

   always #10 clk = ~clk;

   omega_net #(.NPORT(N), .DATA_W(W), .REG_OUT(1'b1)) uut (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_dst(in_dst), .in_data(in_data),
      .out_valid(out_valid), .out_data(out_data), .out_src(out_src),
      .blocked(blocked)
   );

   function automatic int rotl3(int x);
      return ((x << 1) | (x >> (L - 1))) & (N - 1);
   endfunction

   function automatic int unsigned next_rand();
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >> 17);
      seed = seed ^ (seed << 5);
      return seed;
   endfunction

   task automatic drive();
      for (int i = 0; i < N; i++) begin
         in_valid[i]       = (mv[i] != 0);
         in_dst[i*L +: L]  = L'(md[i]);
         in_data[i*W +: W] = mdat[i];
      end
   endtask

   // Path model: after rank k the packet sits on the window of bits
   // {src,dst} ending at destination bit (L-1-k); smaller box input wins.
   task automatic expect_result(output logic [N-1:0] ev, output logic [N*W-1:0] ed,
                                output logic [N*L-1:0] es, output logic [N-1:0] eb);
      int alive [N];
      int prev [N];
      int pin [N];
      int pout [N];
      int kill [N];
      for (int i = 0; i < N; i++) begin
         alive[i] = mv[i];
         prev[i] = i;
      end
      for (int k = 0; k < L; k++) begin
         for (int i = 0; i < N; i++) begin
            pin[i]  = rotl3(prev[i]);
            pout[i] = ((i << (k + 1)) | (md[i] >> (L - 1 - k))) & (N - 1);
            kill[i] = 0;
         end
         for (int i = 0; i < N; i++)
            for (int j = i + 1; j < N; j++)
               if (alive[i] != 0 && alive[j] != 0 && pout[i] == pout[j]) begin
                  if (pin[i] < pin[j]) kill[j] = 1; else kill[i] = 1;
               end
         for (int i = 0; i < N; i++) begin
            if (kill[i] != 0) alive[i] = 0;
            prev[i] = pout[i];
         end
      end
      ev = '0; ed = '0; es = '0; eb = '0;
      for (int i = 0; i < N; i++) begin
         if (mv[i] != 0 && alive[i] == 0) eb[i] = 1'b1;
         if (alive[i] != 0) begin
            ev[md[i]] = 1'b1;
            ed[md[i]*W +: W] = mdat[i];
            es[md[i]*L +: L] = L'(i);
         end
      end
   endtask

   task automatic compare(string req);
      logic [N-1:0]   ev, eb;
      logic [N*W-1:0] ed, ad;
      logic [N*L-1:0] es, as_;
      expect_result(ev, ed, es, eb);
      ad = '0; as_ = '0;
      for (int o = 0; o < N; o++)
         if (out_valid[o]) begin
            ad[o*W +: W] = out_data[o*W +: W];
            as_[o*L +: L] = out_src[o*L +: L];
         end
      checks++;
      if (out_valid !== ev || blocked !== eb || ad !== ed || as_ !== es) begin
         errors++;
         $display("FAIL %s: valid=%h blocked=%h data=%h src=%h expected valid=%h blocked=%h data=%h src=%h",
                  req, out_valid, blocked, ad, as_, ev, eb, ed, es);
      end
   endtask

   task automatic apply(string req);
      @(negedge clk);
      drive();
      @(negedge clk);
      compare(req);
   endtask

   task automatic check_vec(string req, logic [N-1:0] act, logic [N-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic clear_model();
      for (int i = 0; i < N; i++) begin
         mv[i] = 0; md[i] = 0; mdat[i] = '0;
      end
   endtask

   // R1: reset holds outputs at zero even with busy inputs
   task automatic t_reset();
      for (int i = 0; i < N; i++) begin
         mv[i] = 1; md[i] = i; mdat[i] = W'(8'hA0 + i);
      end
      drive();
      repeat (3) @(negedge clk);
      check_vec("R1 valid", out_valid, '0);
      check_vec("R1 blocked", blocked, '0);
      rst_n = 1'b1;
   endtask

   // R2 R5: identity mapping delivered in full
   task automatic t_identity();
      for (int i = 0; i < N; i++) begin
         mv[i] = 1; md[i] = i; mdat[i] = W'(8'h30 + 7 * i);
      end
      apply("R2 identity");
      check_vec("R5 identity all delivered", out_valid, 8'hFF);
   endtask

   // R7: every cyclic shift passes without conflict
   task automatic t_shift();
      for (int c = 0; c < N; c++) begin
         for (int i = 0; i < N; i++) begin
            mv[i] = 1; md[i] = (i + c) % N; mdat[i] = W'(16 * c + i);
         end
         apply("R7 shift");
         check_vec("R7 shift no block", blocked, '0);
      end
   endtask

   // R3: sources 0 and 4 collide in first-rank box 0; source 0 wins
   task automatic t_conflict();
      clear_model();
      mv[0] = 1; md[0] = 3; mdat[0] = 8'h5A;
      mv[4] = 1; md[4] = 2; mdat[4] = 8'hC3;
      apply("R3 pair");
      check_vec("R3 blocked loser", blocked, 8'b0001_0000);
      check_vec("R3 winner only", out_valid, 8'b0000_1000);
   endtask

   // R4: invalid source 0 with a clashing destination does not stop source 4
   task automatic t_invalid();
      clear_model();
      mv[0] = 0; md[0] = 3; mdat[0] = 8'h5A;
      mv[4] = 1; md[4] = 2; mdat[4] = 8'hC3;
      apply("R4 idle rival");
      check_vec("R4 no block", blocked, '0);
      check_vec("R4 delivered", out_valid, 8'b0000_0100);
   endtask

   // R6: registered outputs hold until the next rising edge
   task automatic t_latency();
      for (int i = 0; i < N; i++) begin
         mv[i] = 1; md[i] = i; mdat[i] = W'(i);
      end
      apply("R6 setup");
      @(negedge clk);
      clear_model();
      mv[0] = 1; md[0] = 7; mdat[0] = 8'h77;
      drive();
      #5;
      check_vec("R6 before edge", out_valid, 8'hFF);
      @(negedge clk);
      check_vec("R6 after edge", out_valid, 8'h80);
      compare("R6 after edge payload");
   endtask

   // R2 R3 R5: random destination sets, including sink clashes
   task automatic t_random();
      for (int t = 0; t < 60; t++) begin
         for (int i = 0; i < N; i++) begin
            mv[i] = ((next_rand() & 32'h3) != 0) ? 1 : 0;
            md[i] = int'(next_rand() % N);
            mdat[i] = W'(next_rand());
         end
         apply("R5 random");
      end
   endtask

   initial begin
      clear_model();
      t_reset();
      t_identity();
      t_shift();
      t_conflict();
      t_invalid();
      t_latency();
      t_random();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule